// File: doc/BRIEF.md
# Per-Band SNR and Over-Subtraction Factor Unit

This unit sits in a multi-band spectral-subtraction noise reducer. A frequency-domain front end streams one bin per cycle: the bin number, the noisy-speech power of that bin and the estimated noise power of the same bin. The unit splits the bins into four equal bands and keeps two running sums per band, one for the noisy power and one for the noise power. A frame-end strobe closes the frame. The unit then turns each pair of sums into a segmental signal-to-noise ratio in decibels, without a divider, by subtracting base-2 logarithms and scaling the result.

Each band's SNR is mapped to an over-subtraction factor. The factor is large for bands buried in noise, falls linearly across the middle range and settles at unity for clean bands. The four SNR values and four factors are published together with a one-cycle done pulse. They stay fixed until the next frame has been evaluated, so the subtraction stage downstream can use them for the whole of the following frame.

Top module: `band_snr_alpha`

## Requirements
- R1: A sample enters band i (i = 0..3) only when `smp_valid` is high and `smp_bin[7:4]` equals i. A sample with `smp_valid` low, or with a bin number of 64 or more, changes no sum.
- R2: A sample presented in the same cycle as `frame_end` belongs to the frame that is closing. Every sum restarts from zero for the next frame, so no frame's result depends on an earlier frame.
- R3: Lane i of `snr_db` (bits [24i+23:24i]) holds 10·log10(ΣY/ΣD) for band i as signed two's complement with 18 fractional bits. It is computed from base-2 logarithms that use a 16-entry mantissa table, and it is within 0.3 dB of the exact value. It is exact to within 0.02 dB when both sums are powers of two.
- R4: A sum of zero is treated as one. An SNR outside the 24-bit range saturates to ±(2^23−1)/2^18 dB.
- R5: Lane i of `over_fac` (same bit positions, same format) is 4.75 (0x130000) when the SNR is below −5 dB and 1.0 (0x040000) when the SNR is above 20 dB. Between these limits, inclusive, it is 4 − 0.15·SNR.
- R6: All outputs update together. `fac_done` is high for exactly the one cycle that follows the third rising edge, counting the edge that samples `frame_end`. At all other times the outputs hold their values.
- R7: After reset every factor reads 4.75, every SNR reads 0 and `fac_done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Bin sample present this cycle |
| smp_bin | input | 8 | Frequency bin number |
| sig_pwr | input | 32 | Noisy-speech power of the bin |
| noise_pwr | input | 32 | Estimated noise power of the bin |
| frame_end | input | 1 | Closes the current frame |
| snr_db | output | 96 | Four signed Q18 band SNR values in dB |
| over_fac | output | 96 | Four signed Q18 over-subtraction factors |
| fac_done | output | 1 | One-cycle pulse when the outputs are updated |

## Verification
The bench checks the two knees of the factor law and the flat regions beyond them. A wrong comparator or a swapped multiplexer would produce factors outside the range 1 to 4.75, or a slope where the factor should be flat. It also drives frames in which one band has a zero sum and frames whose power ratio exceeds the 24-bit range. An unclamped logarithm or an unsaturated product would show there as a wrapped SNR of the wrong sign. Further cases close a frame on an in-band sample, close a frame on a cycle with no valid sample, and feed invalid and out-of-range bins carrying large values. A design that dropped the closing sample, failed to clear its sums or leaked ignored samples into a band would report a shifted SNR.

// File: rtl/bsnr_pkg.sv
package bsnr_pkg;
    localparam int QW     = 24;
    localparam int QF     = 18;
    localparam int MANT_W = 4;

    localparam logic signed [QW-1:0] FAC_CEIL  = QW'(1245184);   // 4.75
    localparam logic signed [QW-1:0] FAC_FLOOR = QW'(262144);    // 1.0
    localparam logic signed [QW-1:0] FAC_BASE  = QW'(1048576);   // 4.0
    localparam logic signed [QW-1:0] KNEE_LO   = QW'(-1310720);  // -5 dB
    localparam logic signed [QW-1:0] KNEE_HI   = QW'(5242880);   // 20 dB
    localparam logic signed [QW-1:0] SNR_TOP   = QW'(8388607);
    localparam logic signed [QW-1:0] SNR_BOT   = QW'(-8388607);
    localparam logic signed [17:0]   SLOPE_Q   = 18'sd39322;     // 0.15
    localparam logic signed [21:0]   OCT_DB_Q  = 22'sd789133;    // 10*log10(2)

    // log2(1 + m/16) in Q18, truncated mantissa index
    function automatic logic [QF-1:0] mant_log2(input logic [MANT_W-1:0] m);
        case (m)
            4'd0:  return 18'd0;
            4'd1:  return 18'd22928;
            4'd2:  return 18'd44545;
            4'd3:  return 18'd64993;
            4'd4:  return 18'd84392;
            4'd5:  return 18'd102844;
            4'd6:  return 18'd120437;
            4'd7:  return 18'd137248;
            4'd8:  return 18'd153344;
            4'd9:  return 18'd168783;
            4'd10: return 18'd183616;
            4'd11: return 18'd197889;
            4'd12: return 18'd211643;
            4'd13: return 18'd224914;
            4'd14: return 18'd237736;
            default: return 18'd250137;
        endcase
    endfunction
endpackage

// File: rtl/bsnr_log2.sv
module bsnr_log2
    import bsnr_pkg::*;
#(
    parameter int ACC_W = 40,
    localparam int PW = $clog2(ACC_W),
    localparam int LW = PW + QF
) (
    input  logic [ACC_W-1:0] value,
    output logic [LW-1:0]    log2_q
);
    logic [PW-1:0]     lead;
    logic [ACC_W-1:0]  norm;
    logic [MANT_W-1:0] mant;

    always_comb begin
        lead = '0;
        for (int b = 0; b < ACC_W; b++) begin
            if (value[b]) lead = PW'(b);
        end
        norm   = value << (PW'(ACC_W - 1) - lead);
        mant   = norm[ACC_W-2 -: MANT_W];
        // zero is clamped to the log of one
        log2_q = (value == '0) ? '0 : {lead, mant_log2(mant)};
    end
endmodule

// File: rtl/bsnr_band_acc.sv
module bsnr_band_acc #(
    parameter int POW_W = 32,
    parameter int ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             frame_end,
    input  logic [POW_W-1:0] sig_pwr,
    input  logic [POW_W-1:0] noise_pwr,
    output logic [ACC_W-1:0] tot_y,
    output logic [ACC_W-1:0] tot_d
);
    typedef struct packed {
        logic [ACC_W-1:0] acc_y;
        logic [ACC_W-1:0] acc_d;
        logic [ACC_W-1:0] tot_y;
        logic [ACC_W-1:0] tot_d;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [ACC_W-1:0] sum_y, sum_d;

    always_comb begin
        st_d  = st_q;
        sum_y = st_q.acc_y + (hit ? ACC_W'(sig_pwr)   : '0);
        sum_d = st_q.acc_d + (hit ? ACC_W'(noise_pwr) : '0);
        if (frame_end) begin
            st_d.tot_y = sum_y;
            st_d.tot_d = sum_d;
            st_d.acc_y = '0;
            st_d.acc_d = '0;
        end else begin
            st_d.acc_y = sum_y;
            st_d.acc_d = sum_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tot_y = st_q.tot_y;
    assign tot_d = st_q.tot_d;
endmodule

// File: rtl/bsnr_fac_map.sv
module bsnr_fac_map
    import bsnr_pkg::*;
(
    input  logic [QW-1:0] snr,
    output logic [QW-1:0] fac
);
    localparam int PRW = QW + 18;

    logic signed [QW-1:0]  s;
    logic signed [PRW-1:0] p;
    logic signed [QW-1:0]  red;

    always_comb begin
        s   = $signed(snr);
        p   = PRW'(s) * PRW'(SLOPE_Q);
        red = p[QF +: QW];
        if (s < KNEE_LO)      fac = FAC_CEIL;
        else if (s > KNEE_HI) fac = FAC_FLOOR;
        else                  fac = FAC_BASE - red;
    end
endmodule

// File: rtl/band_snr_alpha.sv
module band_snr_alpha
    import bsnr_pkg::*;
#(
    parameter int NBANDS  = 4,
    parameter int BAND_LG = 4,
    parameter int BIN_W   = 8,
    parameter int POW_W   = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic [BIN_W-1:0]       smp_bin,
    input  logic [POW_W-1:0]       sig_pwr,
    input  logic [POW_W-1:0]       noise_pwr,
    input  logic                   frame_end,
    output logic [NBANDS*QW-1:0]   snr_db,
    output logic [NBANDS*QW-1:0]   over_fac,
    output logic                   fac_done
);
    localparam int ACC_W = POW_W + BIN_W;
    localparam int LW    = $clog2(ACC_W) + QF;
    localparam int PRW   = LW + 23;
    localparam int SEL_W = BIN_W - BAND_LG;

    typedef struct packed {
        logic                           fe1;
        logic                           fe2;
        logic [NBANDS-1:0][QW-1:0]      snr_mid;
        logic [NBANDS-1:0][QW-1:0]      snr_out;
        logic [NBANDS-1:0][QW-1:0]      fac_out;
        logic                           done;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [QW-1:0] snr_w [NBANDS];
    logic [QW-1:0] fac_w [NBANDS];

    for (genvar g = 0; g < NBANDS; g++) begin : g_band
        logic             hit;
        logic [ACC_W-1:0] tot_y, tot_d;
        logic [LW-1:0]    log_y, log_d;
        logic signed [LW:0]    diff;
        logic signed [PRW-1:0] prod, scl;

        assign hit = smp_valid && (smp_bin[BIN_W-1:BAND_LG] == SEL_W'(g));

        bsnr_band_acc #(.POW_W(POW_W), .ACC_W(ACC_W)) acc_i (
            .clk(clk), .rst_n(rst_n), .hit(hit), .frame_end(frame_end),
            .sig_pwr(sig_pwr), .noise_pwr(noise_pwr),
            .tot_y(tot_y), .tot_d(tot_d)
        );

        bsnr_log2 #(.ACC_W(ACC_W)) log_y_i (.value(tot_y), .log2_q(log_y));
        bsnr_log2 #(.ACC_W(ACC_W)) log_d_i (.value(tot_d), .log2_q(log_d));

        always_comb begin
            diff = $signed({1'b0, log_y}) - $signed({1'b0, log_d});
            prod = PRW'(diff) * PRW'(OCT_DB_Q);
            scl  = prod >>> QF;
            if (scl > PRW'(SNR_TOP))      snr_w[g] = SNR_TOP;
            else if (scl < PRW'(SNR_BOT)) snr_w[g] = SNR_BOT;
            else                          snr_w[g] = scl[QW-1:0];
        end

        bsnr_fac_map map_i (.snr(st_q.snr_mid[g]), .fac(fac_w[g]));

        assign snr_db[g*QW +: QW]   = st_q.snr_out[g];
        assign over_fac[g*QW +: QW] = st_q.fac_out[g];
    end

    always_comb begin
        st_d      = st_q;
        st_d.fe1  = frame_end;
        st_d.fe2  = st_q.fe1;
        st_d.done = st_q.fe2;
        for (int i = 0; i < NBANDS; i++) begin
            if (st_q.fe1) st_d.snr_mid[i] = snr_w[i];
            if (st_q.fe2) begin
                st_d.snr_out[i] = st_q.snr_mid[i];
                st_d.fac_out[i] = fac_w[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NBANDS; i++) st_q.fac_out[i] <= FAC_CEIL;
        end else begin
            st_q <= st_d;
        end
    end

    assign fac_done = st_q.done;
endmodule

// File: rtl/band_snr_alpha_chk.sv
module band_snr_alpha_chk
    import bsnr_pkg::*;
#(
    parameter int NBANDS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 frame_end,
    input logic [NBANDS*QW-1:0] snr_db,
    input logic [NBANDS*QW-1:0] over_fac,
    input logic                 fac_done
);
    for (genvar g = 0; g < NBANDS; g++) begin : g_lane
        logic signed [QW-1:0] s, f;
        assign s = $signed(snr_db[g*QW +: QW]);
        assign f = $signed(over_fac[g*QW +: QW]);

        // R5
        fac_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (f >= FAC_FLOOR) && (f <= FAC_CEIL));
        // R5
        fac_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s > KNEE_HI) |-> (f == FAC_FLOOR));
        // R5
        fac_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s < KNEE_LO) |-> (f == FAC_CEIL));
        // R4
        snr_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s >= SNR_BOT) && (s <= SNR_TOP));
    end

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fac_done |-> ($stable(over_fac) && $stable(snr_db)));
    // R6
    done_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fac_done |-> $past(frame_end, 3));
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fac_done && !$past(frame_end, 2)) |=> !fac_done);
endmodule

bind band_snr_alpha band_snr_alpha_chk #(.NBANDS(NBANDS)) chk_i (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
    .snr_db(snr_db), .over_fac(over_fac), .fac_done(fac_done)
);

// File: tb/band_snr_alpha_tb.sv
module band_snr_alpha_tb_top;
    import bsnr_pkg::*;

    localparam int CLK_NS  = 10;
    localparam int NB      = 4;
    localparam int BAND_LG = 4;
    localparam int BIN_W   = 8;
    localparam int POW_W   = 32;
    localparam int NBIN    = 80;
    localparam int INBAND  = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic frame_end = 1'b0;
    logic [BIN_W-1:0] smp_bin = '0;
    logic [POW_W-1:0] sig_pwr = '0;
    logic [POW_W-1:0] noise_pwr = '0;
    logic [NB*QW-1:0] snr_db, over_fac;
    logic             fac_done;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;
    real ey [NB];
    real ed [NB];
    logic [NB*QW-1:0] snap_fac;

    always #(CLK_NS/2) clk = ~clk;

    band_snr_alpha #(.NBANDS(NB), .BAND_LG(BAND_LG), .BIN_W(BIN_W), .POW_W(POW_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_bin(smp_bin),
        .sig_pwr(sig_pwr), .noise_pwr(noise_pwr), .frame_end(frame_end),
        .snr_db(snr_db), .over_fac(over_fac), .fac_done(fac_done)
    );

    function automatic real q2r(input logic [QW-1:0] x);
        return real'($signed(x)) / 262144.0;
    endfunction

    function automatic real exp_snr(input real y, input real d);
        real yy, dd, s, lim;
        yy  = (y < 1.0) ? 1.0 : y;
        dd  = (d < 1.0) ? 1.0 : d;
        s   = 10.0 * $log10(yy / dd);
        lim = 8388607.0 / 262144.0;
        if (s > lim)  s = lim;
        if (s < -lim) s = -lim;
        return s;
    endfunction

    function automatic real exp_fac(input real s);
        if (s < -5.0) return 4.75;
        if (s > 20.0) return 1.0;
        return 4.0 - 0.15 * s;
    endfunction

    task automatic check_val(input string tag, input real act, input real expv, input real tol);
        real e;
        checks++;
        e = act - expv;
        if (e < 0.0) e = -e;
        if (e > tol) begin
            errors++;
            $display("FAIL %s actual %f expected %f", tag, act, expv);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, expv);
        end
    endtask

    task automatic clear_exp();
        for (int b = 0; b < NB; b++) begin
            ey[b] = 0.0;
            ed[b] = 0.0;
        end
    endtask

    task automatic put(input int bin, input logic [31:0] s, input logic [31:0] n,
                       input logic v, input logic fe);
        longint ls, ln;
        @(negedge clk);
        smp_bin   = BIN_W'(bin);
        sig_pwr   = s;
        noise_pwr = n;
        smp_valid = v;
        frame_end = fe;
        if (v && bin < INBAND) begin
            ls = longint'({32'd0, s});
            ln = longint'({32'd0, n});
            ey[bin >> BAND_LG] = ey[bin >> BAND_LG] + real'(ls);
            ed[bin >> BAND_LG] = ed[bin >> BAND_LG] + real'(ln);
        end
    endtask

    // called right after the put that carries frame_end
    task automatic finish_frame(input string tag, input real tol_s, input real tol_f);
        real es;
        @(negedge clk);
        smp_valid = 1'b0;
        frame_end = 1'b0;
        snap_fac  = over_fac;
        check_bit({tag, " R6 done early"}, fac_done, 1'b0);
        @(negedge clk);
        check_bit({tag, " R6 done early"}, fac_done, 1'b0);
        checks++;
        if (over_fac !== snap_fac) begin
            errors++;
            $display("FAIL %s R6 held factors actual %h expected %h", tag, over_fac, snap_fac);
        end
        @(negedge clk);
        check_bit({tag, " R6 done pulse"}, fac_done, 1'b1);
        for (int b = 0; b < NB; b++) begin
            es = exp_snr(ey[b], ed[b]);
            check_val($sformatf("%s R3 snr band %0d", tag, b), q2r(snr_db[b*QW +: QW]), es, tol_s);
            check_val($sformatf("%s R5 factor band %0d", tag, b), q2r(over_fac[b*QW +: QW]),
                      exp_fac(es), tol_f);
        end
        @(negedge clk);
        check_bit({tag, " R6 done end"}, fac_done, 1'b0);
    endtask

    // R1: invalid and out-of-range bins carry large values, frame closes on an idle cycle
    task automatic frame_ignore(input string tag);
        clear_exp();
        put(3,  32'd1 << 24, 32'd1 << 14, 1'b1, 1'b0);
        put(5,  32'hFFFF_FFFF, 32'd1, 1'b0, 1'b0);
        put(17, 32'd1 << 10, 32'd1 << 12, 1'b1, 1'b0);
        put(40, 32'd1 << 13, 32'd1 << 10, 1'b1, 1'b0);
        put(70, 32'hFFFF_FFFF, 32'd7, 1'b1, 1'b0);
        put(66, 32'd9, 32'hFFFF_0000, 1'b1, 1'b0);
        put(8,  32'd0, 32'd0, 1'b0, 1'b1);
        finish_frame(tag, 0.02, 0.01);
    endtask

    task automatic frame_random(input int idx);
        int na [NB];
        int sa [NB];
        logic v;
        logic [31:0] s, n;
        clear_exp();
        for (int b = 0; b < NB; b++) begin
            na[b] = int'($urandom_range(8, 22));
            sa[b] = na[b] + int'($urandom_range(0, 16)) - 8;
        end
        for (int bin = 0; bin < NBIN; bin++) begin
            v = ($urandom_range(0, 7) != 0);
            if (bin < INBAND) begin
                s = $urandom_range(1, 32'd1 << sa[bin >> BAND_LG]);
                n = $urandom_range(1, 32'd1 << na[bin >> BAND_LG]);
            end else begin
                s = $urandom();
                n = $urandom();
            end
            put(bin, s, n, v, bin == NBIN - 1);
        end
        finish_frame($sformatf("random frame %0d", idx), 0.4, 0.08);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R6 actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        // R7 reset values
        for (int b = 0; b < NB; b++) begin
            check_val($sformatf("R7 reset factor band %0d", b), q2r(over_fac[b*QW +: QW]), 4.75, 0.0);
            check_val($sformatf("R7 reset snr band %0d", b), q2r(snr_db[b*QW +: QW]), 0.0, 0.0);
        end
        check_bit("R7 reset done", fac_done, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        frame_ignore("R1 directed");

        // R4 saturation and zero sums; R2 frame closes on an in-band sample
        clear_exp();
        for (int bin = 0; bin < 16; bin++) put(bin, 32'd1 << 31, 32'd0, 1'b1, 1'b0);
        put(16, 32'd0, 32'd1 << 31, 1'b1, 1'b0);
        put(32, 32'd1 << 20, 32'd1 << 20, 1'b1, 1'b0);
        put(60, 32'd1 << 20, 32'd1 << 16, 1'b1, 1'b1);
        finish_frame("R4 R2 saturation", 0.02, 0.01);

        // R6 outputs hold while idle
        snap_fac = over_fac;
        repeat (6) @(negedge clk);
        check_bit("R6 idle done", fac_done, 1'b0);
        checks++;
        if (over_fac !== snap_fac) begin
            errors++;
            $display("FAIL R6 idle hold actual %h expected %h", over_fac, snap_fac);
        end

        // R2 sums cleared: same frame again must match, band 3 empty
        frame_ignore("R2 repeat");

        for (int f = 0; f < 30; f++) frame_random(f);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule